// File: doc/BRIEF.md
# Inverting Two-Way Latched Transceiver

This block connects two 8-bit ports, A and B. It keeps a separate word of storage for each direction of transfer. Each direction has three active-low controls: a chip enable, a load enable and an output enable. While a direction's chip enable and load enable are both low, its storage is transparent and follows the source port. When either control rises, the storage holds its word. The destination port is driven with the bitwise complement of the stored word, but only while that direction's chip enable and output enable are both low.

The block targets a clocked fabric, so the transparent latches are emulated by sampling on the system clock. Each port has a separate input bus, output bus and active-high drive-enable. A tri-state pad wrapper at chip level uses the drive-enable to turn the output bus into the real bidirectional pin. Every output is registered, which gives one clock of latency from any input or control to the port it affects. The stored words have no reset. Reset only forces both drive-enables low.

Top module: `inv_latch_xcvr`

## Requirements
- R1: While `ab_ce_n` and `ab_le_n` are both low at a clock edge, the A-to-B storage takes `a_i`. The value appears on `b_o` after that edge, so the bench sees it one cycle later.
- R2: While `ab_ce_n` is low and `ab_le_n` is high, the stored A-to-B word holds. Changes on `a_i` have no effect on `b_o`.
- R3: While `ab_ce_n` is high, the stored A-to-B word holds even if `ab_le_n` is low. After chip enable returns low with load enable high, `b_o` shows the word stored before chip enable rose.
- R4: `b_oe` is 1 after a clock edge exactly when `ab_ce_n` and `ab_oe_n` were both low at that edge. When `b_oe` is 1, `b_o` is the current A-to-B stored word.
- R5: Whenever `ab_ce_n` is high at an edge, `b_oe` is 0 after that edge, whatever the values of `ab_le_n`, `ab_oe_n` and `a_i`.
- R6: Each bit of a port output is the logical inverse of the matching stored bit: a stored 0 gives 1 and a stored 1 gives 0, bit i to bit i.
- R7: The B-to-A direction behaves exactly like A-to-B. It uses `ba_ce_n`, `ba_le_n`, `ba_oe_n`, `b_i`, `a_o` and `a_oe`, and keeps its own stored word. Activity in one direction never changes the other direction's word or drive-enable.
- R8: An edge with `rst` high forces `a_oe` and `b_oe` to 0. Reset does not clear the stored words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state samples on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the drive-enables |
| a_i | input | 8 | Data arriving on port A |
| a_o | output | 8 | Inverted B-to-A stored word toward port A |
| a_oe | output | 1 | Drive-enable for port A, active high |
| b_i | input | 8 | Data arriving on port B |
| b_o | output | 8 | Inverted A-to-B stored word toward port B |
| b_oe | output | 1 | Drive-enable for port B, active high |
| ab_ce_n | input | 1 | A-to-B chip enable, active low |
| ab_le_n | input | 1 | A-to-B load enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_ce_n | input | 1 | B-to-A chip enable, active low |
| ba_le_n | input | 1 | B-to-A load enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
All 256 data words are passed through each direction with the storage transparent. This separates a correct complement from a missing, partial or bit-swapped inversion. All eight combinations of the three controls are then stepped in both directions while the source data changes on every step, and the outputs are compared with a reference word that is updated only when load is allowed. This pattern exposes a load that ignores the chip enable, a drive that ignores either enable, and a hold that leaks. A cross-direction phase keeps one word held while the other direction reloads, which shows whether the two stored words stay independent. Reset is then applied mid-stream to confirm that it clears only the drive-enables.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_WIDTH = 8;

  typedef struct packed {
    logic ce_n;
    logic le_n;
    logic oe_n;
  } dir_ctl_t;

  function automatic logic ctl_load(input dir_ctl_t c);
    return (~c.ce_n) & (~c.le_n);
  endfunction

  function automatic logic ctl_drive(input dir_ctl_t c);
    return (~c.ce_n) & (~c.oe_n);
  endfunction
endpackage

// File: rtl/xcvr_bit_cell.sv
module xcvr_bit_cell (
  input  logic clk,
  input  logic rst,
  input  logic ld,
  input  logic d,
  output logic q_n
);
  logic held;
  logic nxt;

  assign nxt = ld ? d : held;

  // storage emulating a level latch; intentionally no reset
  always_ff @(posedge clk) begin
    held <= nxt;
    q_n  <= ~nxt;
  end

  // R6: the output bit is the complement of the bit just loaded
  p_bit_invert_r6: assert property (@(posedge clk) disable iff (rst)
    ld |=> (q_n == !$past(d)));
endmodule

// File: rtl/xcvr_dir.sv
module xcvr_dir #(
  parameter int unsigned WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  xcvr_pkg::dir_ctl_t ctl,
  input  logic [WIDTH-1:0]   din,
  output logic [WIDTH-1:0]   dout,
  output logic               oe
);
  import xcvr_pkg::*;

  logic ld;
  logic drv;

  assign ld  = ctl_load(ctl);
  assign drv = ctl_drive(ctl);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    xcvr_bit_cell u_cell (
      .clk (clk),
      .rst (rst),
      .ld  (ld),
      .d   (din[i]),
      .q_n (dout[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) oe <= 1'b0;
    else     oe <= drv;
  end

  p_load_follow_r1: assert property (@(posedge clk) disable iff (rst)
    (!ctl.ce_n && !ctl.le_n) |=> (dout == ~$past(din)));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!ctl.ce_n && ctl.le_n) |=> $stable(dout));

  p_freeze_r3: assert property (@(posedge clk) disable iff (rst)
    ctl.ce_n |=> $stable(dout));

  p_drive_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctl.ce_n && !ctl.oe_n) |=> oe);

  p_float_r5: assert property (@(posedge clk) disable iff (rst)
    ctl.ce_n |=> !oe);

  p_rst_quiet_r8: assert property (@(posedge clk)
    rst |=> !oe);
endmodule

// File: rtl/inv_latch_xcvr.sv
module inv_latch_xcvr #(
  parameter int unsigned WIDTH = xcvr_pkg::XCVR_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] a_o,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] b_o,
  output logic             b_oe,
  input  logic             ab_ce_n,
  input  logic             ab_le_n,
  input  logic             ab_oe_n,
  input  logic             ba_ce_n,
  input  logic             ba_le_n,
  input  logic             ba_oe_n
);
  import xcvr_pkg::*;

  dir_ctl_t ab_ctl;
  dir_ctl_t ba_ctl;

  assign ab_ctl = '{ce_n: ab_ce_n, le_n: ab_le_n, oe_n: ab_oe_n};
  assign ba_ctl = '{ce_n: ba_ce_n, le_n: ba_le_n, oe_n: ba_oe_n};

  // A to B
  xcvr_dir #(.WIDTH(WIDTH)) u_ab (
    .clk  (clk),
    .rst  (rst),
    .ctl  (ab_ctl),
    .din  (a_i),
    .dout (b_o),
    .oe   (b_oe)
  );

  // B to A, R7
  xcvr_dir #(.WIDTH(WIDTH)) u_ba (
    .clk  (clk),
    .rst  (rst),
    .ctl  (ba_ctl),
    .din  (b_i),
    .dout (a_o),
    .oe   (a_oe)
  );
endmodule

// File: tb/inv_latch_xcvr_test.sv
`timescale 1ns/1ps
module inv_latch_xcvr_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a_i = '0, b_i = '0;
  logic [7:0] a_o, b_o;
  logic       a_oe, b_oe;
  logic       ab_ce_n = 1'b1, ab_le_n = 1'b1, ab_oe_n = 1'b1;
  logic       ba_ce_n = 1'b1, ba_le_n = 1'b1, ba_oe_n = 1'b1;
  int         checks = 0;
  int         fails = 0;
  logic [7:0] m_ab, m_ba;

  always #4 clk = ~clk;

  inv_latch_xcvr uut (
    .clk(clk), .rst(rst),
    .a_i(a_i), .a_o(a_o), .a_oe(a_oe),
    .b_i(b_i), .b_o(b_o), .b_oe(b_oe),
    .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #1600000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    chk("R8 reset a_oe", {7'd0, a_oe}, 8'd0);
    chk("R8 reset b_oe", {7'd0, b_oe}, 8'd0);
    rst = 1'b0;

    // R1 and R6: full sweep in both directions, transparent
    ab_ce_n = 0; ab_le_n = 0; ab_oe_n = 0;
    ba_ce_n = 0; ba_le_n = 0; ba_oe_n = 0;
    for (int v = 0; v < 256; v++) begin
      a_i = 8'(v);
      b_i = 8'(255 - v);
      step();
      chk("R1/R6 b_o", b_o, ~8'(v));
      chk("R7/R6 a_o", a_o, ~8'(255 - v));
      chk("R4 b_oe", {7'd0, b_oe}, 8'd1);
    end

    // R2: hold with load enable high
    a_i = 8'h5A; step();
    ab_le_n = 1;
    for (int v = 0; v < 6; v++) begin
      a_i = 8'(v * 41 + 3);
      step();
      chk("R2 hold b_o", b_o, 8'hA5);
    end

    // R3: chip enable high freezes even with load enable low
    ab_le_n = 0; a_i = 8'h3C; step();
    ab_ce_n = 1;
    for (int v = 0; v < 4; v++) begin
      a_i = 8'(v * 77 + 1);
      step();
      chk("R5 ce high b_oe", {7'd0, b_oe}, 8'd0);
    end
    ab_ce_n = 0; ab_le_n = 1; a_i = 8'hFF;
    step();
    chk("R3 freeze b_o", b_o, 8'hC3);
    chk("R4 b_oe", {7'd0, b_oe}, 8'd1);

    // R4/R5: all control combinations, both directions, with a reference model
    m_ab = 8'h3C;
    ba_le_n = 0; b_i = 8'h81; step(); m_ba = 8'h81;
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < 8; c++) begin
        {ab_ce_n, ab_le_n, ab_oe_n} = 3'(c);
        {ba_ce_n, ba_le_n, ba_oe_n} = 3'(7 - c);
        a_i = 8'(c * 29 + r * 53 + 7);
        b_i = 8'(c * 67 + r * 11 + 90);
        if (!ab_ce_n && !ab_le_n) m_ab = a_i;
        if (!ba_ce_n && !ba_le_n) m_ba = b_i;
        step();
        chk("R4/R5 b_oe", {7'd0, b_oe}, {7'd0, !ab_ce_n && !ab_oe_n});
        chk("R7 a_oe", {7'd0, a_oe}, {7'd0, !ba_ce_n && !ba_oe_n});
        if (b_oe) chk("R4 b_o data", b_o, ~m_ab);
        if (a_oe) chk("R7 a_o data", a_o, ~m_ba);
      end
    end

    // R7: independence of stored words
    ab_ce_n = 0; ab_le_n = 0; ab_oe_n = 0; a_i = 8'hF0;
    ba_ce_n = 0; ba_le_n = 0; ba_oe_n = 0; b_i = 8'h0F;
    step();
    ba_le_n = 1;
    for (int v = 0; v < 8; v++) begin
      a_i = 8'(v * 33 + 5);
      b_i = 8'(v * 19);
      step();
      chk("R7 a_o held", a_o, 8'hF0);
      chk("R1 b_o follows", b_o, ~8'(v * 33 + 5));
    end

    // R8: reset clears drive-enables but not stored words
    ab_le_n = 1;
    rst = 1;
    step();
    chk("R8 a_oe in reset", {7'd0, a_oe}, 8'd0);
    chk("R8 b_oe in reset", {7'd0, b_oe}, 8'd0);
    rst = 0;
    step();
    chk("R8 a_oe after", {7'd0, a_oe}, 8'd1);
    chk("R8 a_o kept", a_o, 8'hF0);
    chk("R8 b_o kept", b_o, ~8'(7 * 33 + 5));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule